// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words. Each word holds a sign in bit 31, an 8-bit exponent in bits 30..23 stored with a bias of 127, and a 23-bit fraction in bits 22..0 that sits behind an implied leading 1. An operation bit picks addition (0) or subtraction (1). Subtraction inverts the sign of the second operand and then runs the same path as addition.

The datapath has three register stages. The first stage classifies the operands and settles zero and infinity cases. It orders the operands by magnitude and shifts the smaller significand right. The second stage adds or subtracts the aligned significands. The third stage normalizes the sum and rounds it on two extension bits, guard and round. It then checks the exponent range and packs the result together with an overflow flag and an underflow flag.

Operands with exponent field 0 are flushed to zero. Any exponent field of 255 is read as infinity, even when the fraction is nonzero. A new operation can be accepted on every cycle once reset has ended.

Top module: `fpadd_top`

## Requirements
- R1: Normal operands (exponent field 1..254) produce the correctly rounded sum in the same format, for example 1.0 + 2.0 = 0x40400000 and (-5.0) + (-0.75) = 0xC0B80000.
- R2: With `in_op` = 1 the result equals A plus B with the sign bit of B inverted, for example 0.5 - 0.4375 = 0x3D800000.
- R3: An operand whose exponent field is 0 counts as zero, whatever its fraction. If A is zero, the result is B with its effective sign and with its fraction cleared when B is also zero. Otherwise, if B is zero, the result is A bit for bit. No flag is raised.
- R4: The significand with the smaller magnitude is shifted right by the exponent difference. Only two bits below the last fraction bit (guard, then round) are kept. A difference of 26 or more removes the operand entirely.
- R5: A sum of 2 or more is shifted right by one place with the exponent raised by one. A sum below 1 is shifted left until bit 23 of the significand is 1, with the exponent lowered to match.
- R6: Rounding is to nearest with ties to even. The result rounds up when guard = 1 and either round = 1 or the result LSB = 1. A carry out of the rounded significand gives significand 1.0 and raises the exponent by one.
- R7: Operands of equal magnitude and opposite effective signs give +0 (0x00000000).
- R8: A final biased exponent above 254 (unbiased above 127), including one caused by rounding, sets `out_overflow`. The result is then the signed infinity: exponent field 255, fraction 0.
- R9: A final biased exponent below 1 (unbiased below -126) sets `out_underflow`. The result is then a zero carrying the result sign.
- R10: If either operand has exponent field 255, the result is an infinity (fraction 0). When A is infinite it takes the sign of A. Otherwise it takes the effective sign of B. No flag is raised.
- R11: Two infinite operands with opposite effective signs give 0x7FC00000 and no flag.
- R12: `in_ready` is 0 while reset is asserted and 1 after reset ends. `out_valid` is 0 after reset. A transfer accepted at a clock edge (`in_valid` and `in_ready` both 1) produces its result with `out_valid` = 1 exactly three edges later, and results come out in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation are presented |
| in_ready | output | 1 | Block accepts a transfer on this edge |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_op | input | 1 | 0 = add, 1 = subtract |
| out_valid | output | 1 | Result and flags are valid |
| out_result | output | 32 | Rounded result |
| out_overflow | output | 1 | Exponent range exceeded; result is infinity |
| out_underflow | output | 1 | Exponent below range; result is zero |

## Verification
Rounding and overflow detection can act on the same result. This happens when a rounding carry pushes the largest finite exponent up to 255. The bench provokes it with 0x7F7FFFFF + 0x73000000. Here the addend lands exactly on the guard bit and the LSB is odd, so the sum rounds up and carries. The check expects the infinity code together with the overflow flag, not a finite value with a raised exponent. The same vectors are also sent back to back and mixed with idle gaps. This confirms that each result appears three edges after it was accepted and that results stay in order.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2
  } fp_class_e;

endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_fire,
  input  logic [EXP_W+FRAC_W:0]    in_a,
  input  logic [EXP_W+FRAC_W:0]    in_b,
  input  logic                     in_op,
  output logic                     s1_valid,
  output logic                     s1_bypass,
  output logic [EXP_W+FRAC_W:0]    s1_res,
  output logic                     s1_sign,
  output logic                     s1_sub,
  output logic [EXP_W-1:0]         s1_exp,
  output logic [FRAC_W+2:0]        s1_big,
  output logic [FRAC_W+2:0]        s1_small
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int EXT_W = FRAC_W + 3;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W-1:0] SH_LIM   = EXP_W'(EXT_W);
  localparam logic [W-1:0] NAN_CODE = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb, big_e, sml_e, diff;
  logic [FRAC_W-1:0] fa, fb;
  fp_class_e         cls_a, cls_b;
  logic              a_ge;
  logic [EXT_W-1:0]  big_m, sml_m, sml_sh;
  logic              bypass_d;
  logic [W-1:0]      res_d;

  always_comb begin
    sa = in_a[W-1];
    sb = in_b[W-1] ^ in_op;
    ea = in_a[W-2:FRAC_W];
    eb = in_b[W-2:FRAC_W];
    fa = in_a[FRAC_W-1:0];
    fb = in_b[FRAC_W-1:0];

    if (ea == '0)            cls_a = CLS_ZERO;
    else if (ea == EXP_ONES) cls_a = CLS_INF;
    else                     cls_a = CLS_NORM;
    if (eb == '0)            cls_b = CLS_ZERO;
    else if (eb == EXP_ONES) cls_b = CLS_INF;
    else                     cls_b = CLS_NORM;

    a_ge   = {ea, fa} >= {eb, fb};
    big_e  = a_ge ? ea : eb;
    sml_e  = a_ge ? eb : ea;
    big_m  = a_ge ? {1'b1, fa, 2'b00} : {1'b1, fb, 2'b00};
    sml_m  = a_ge ? {1'b1, fb, 2'b00} : {1'b1, fa, 2'b00};
    diff   = big_e - sml_e;
    sml_sh = (diff >= SH_LIM) ? '0 : (sml_m >> diff);

    bypass_d = 1'b1;
    res_d    = '0;
    if (cls_a == CLS_INF && cls_b == CLS_INF) begin
      res_d = (sa != sb) ? NAN_CODE : {sa, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (cls_a == CLS_INF) begin
      res_d = {sa, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (cls_b == CLS_INF) begin
      res_d = {sb, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (cls_a == CLS_ZERO) begin
      res_d = (cls_b == CLS_ZERO) ? {sb, {(W-1){1'b0}}} : {sb, in_b[W-2:0]};
    end else if (cls_b == CLS_ZERO) begin
      res_d = in_a;
    end else begin
      bypass_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_fire;
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      s1_bypass <= bypass_d;
      s1_res    <= res_d;
      s1_sign   <= a_ge ? sa : sb;
      s1_sub    <= sa ^ sb;
      s1_exp    <= big_e;
      s1_big    <= big_m;
      s1_small  <= sml_sh;
    end
  end

  AST_ALIGN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_bypass) |-> (s1_big >= s1_small)); // R4

endmodule

// File: rtl/fpadd_sum.sv
module fpadd_sum #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic                     s1_bypass,
  input  logic [EXP_W+FRAC_W:0]    s1_res,
  input  logic                     s1_sign,
  input  logic                     s1_sub,
  input  logic [EXP_W-1:0]         s1_exp,
  input  logic [FRAC_W+2:0]        s1_big,
  input  logic [FRAC_W+2:0]        s1_small,
  output logic                     s2_valid,
  output logic                     s2_bypass,
  output logic [EXP_W+FRAC_W:0]    s2_res,
  output logic                     s2_sign,
  output logic [EXP_W-1:0]         s2_exp,
  output logic [FRAC_W+3:0]        s2_sum
);

  localparam int SUM_W = FRAC_W + 4;

  logic [SUM_W-1:0] sum_d;

  always_comb begin
    if (s1_sub) sum_d = {1'b0, s1_big} - {1'b0, s1_small};
    else        sum_d = {1'b0, s1_big} + {1'b0, s1_small};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_bypass <= s1_bypass;
      s2_res    <= s1_res;
      s2_sign   <= s1_sign;
      s2_exp    <= s1_exp;
      s2_sum    <= sum_d;
    end
  end

  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_bypass && s1_sub) |=> !s2_sum[SUM_W-1]); // R5

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s2_valid,
  input  logic                     s2_bypass,
  input  logic [EXP_W+FRAC_W:0]    s2_res,
  input  logic                     s2_sign,
  input  logic [EXP_W-1:0]         s2_exp,
  input  logic [FRAC_W+3:0]        s2_sum,
  output logic                     out_valid,
  output logic [EXP_W+FRAC_W:0]    out_result,
  output logic                     out_overflow,
  output logic                     out_underflow
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int EXT_W = FRAC_W + 3;
  localparam int SUM_W = FRAC_W + 4;
  localparam int LZW   = $clog2(EXT_W);
  localparam int XW    = EXP_W + 2;
  localparam logic [EXP_W-1:0]     EXP_ONES = '1;
  localparam logic signed [XW-1:0] E_TOP    = XW'((2**EXP_W) - 2);
  localparam logic signed [XW-1:0] E_ONE    = XW'(1);

  logic [LZW-1:0]         pos, lz;
  logic [EXT_W-1:0]       norm_m;
  logic signed [XW-1:0]   norm_e, fin_e;
  logic                   rnd_up, carry;
  logic [MANT_W:0]        mant_r;
  logic [FRAC_W-1:0]      frac;
  logic [W-1:0]           res_d;
  logic                   ovf_d, unf_d;

  always_comb begin
    pos = '0;
    for (int i = 0; i < EXT_W; i++) begin
      if (s2_sum[i]) pos = LZW'(i);
    end
    lz = LZW'(EXT_W - 1) - pos;

    if (s2_sum[SUM_W-1]) begin
      norm_m = s2_sum[SUM_W-1:1];
      norm_e = $signed({2'b00, s2_exp}) + E_ONE;
    end else begin
      norm_m = s2_sum[EXT_W-1:0] << lz;
      norm_e = $signed({2'b00, s2_exp}) - $signed({{(XW-LZW){1'b0}}, lz});
    end

    rnd_up = norm_m[1] & (norm_m[0] | norm_m[2]);
    mant_r = {1'b0, norm_m[EXT_W-1:2]} + {{MANT_W{1'b0}}, rnd_up};
    carry  = mant_r[MANT_W];
    frac   = carry ? mant_r[FRAC_W:1] : mant_r[FRAC_W-1:0];
    fin_e  = norm_e + $signed({{(XW-1){1'b0}}, carry});

    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (s2_bypass) begin
      res_d = s2_res;
    end else if (s2_sum == '0) begin
      res_d = '0;
    end else if (fin_e > E_TOP) begin
      res_d = {s2_sign, EXP_ONES, {FRAC_W{1'b0}}};
      ovf_d = 1'b1;
    end else if (fin_e < E_ONE) begin
      res_d = {s2_sign, {(W-1){1'b0}}};
      unf_d = 1'b1;
    end else begin
      res_d = {s2_sign, fin_e[EXP_W-1:0], frac};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      out_result    <= res_d;
      out_overflow  <= ovf_d;
      out_underflow <= unf_d;
    end
  end

  AST_HIDDEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_bypass && (s2_sum != '0)) |-> norm_m[EXT_W-1]); // R5

endmodule

// File: rtl/fpadd_top.sv
module fpadd_top #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [EXP_W+FRAC_W:0]  in_a,
  input  logic [EXP_W+FRAC_W:0]  in_b,
  input  logic                   in_op,
  output logic                   out_valid,
  output logic [EXP_W+FRAC_W:0]  out_result,
  output logic                   out_overflow,
  output logic                   out_underflow
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int EXT_W = FRAC_W + 3;
  localparam int SUM_W = FRAC_W + 4;

  logic [1:0] rst_pipe;
  logic       rst_n_i;
  logic       rdy_q;
  logic       in_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rdy_q <= 1'b0;
    else          rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign in_fire  = in_valid & rdy_q;

  logic             s1_valid, s1_bypass, s1_sign, s1_sub;
  logic [W-1:0]     s1_res;
  logic [EXP_W-1:0] s1_exp;
  logic [EXT_W-1:0] s1_big, s1_small;

  logic             s2_valid, s2_bypass, s2_sign;
  logic [W-1:0]     s2_res;
  logic [EXP_W-1:0] s2_exp;
  logic [SUM_W-1:0] s2_sum;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) align_i (
    .clk(clk), .rst_n(rst_n_i), .in_fire(in_fire),
    .in_a(in_a), .in_b(in_b), .in_op(in_op),
    .s1_valid(s1_valid), .s1_bypass(s1_bypass), .s1_res(s1_res),
    .s1_sign(s1_sign), .s1_sub(s1_sub), .s1_exp(s1_exp),
    .s1_big(s1_big), .s1_small(s1_small)
  );

  fpadd_sum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) sum_i (
    .clk(clk), .rst_n(rst_n_i),
    .s1_valid(s1_valid), .s1_bypass(s1_bypass), .s1_res(s1_res),
    .s1_sign(s1_sign), .s1_sub(s1_sub), .s1_exp(s1_exp),
    .s1_big(s1_big), .s1_small(s1_small),
    .s2_valid(s2_valid), .s2_bypass(s2_bypass), .s2_res(s2_res),
    .s2_sign(s2_sign), .s2_exp(s2_exp), .s2_sum(s2_sum)
  );

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) round_i (
    .clk(clk), .rst_n(rst_n_i),
    .s2_valid(s2_valid), .s2_bypass(s2_bypass), .s2_res(s2_res),
    .s2_sign(s2_sign), .s2_exp(s2_exp), .s2_sum(s2_sum),
    .out_valid(out_valid), .out_result(out_result),
    .out_overflow(out_overflow), .out_underflow(out_underflow)
  );

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_fire |-> ##3 out_valid); // R12

  AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n_i)
    (out_valid && out_overflow) |-> (out_result[W-2:FRAC_W] == '1 && out_result[FRAC_W-1:0] == '0)); // R8

  AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    (out_valid && out_underflow) |-> (out_result[W-2:0] == '0)); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_valid |-> !(out_overflow && out_underflow)); // R8

endmodule

// File: tb/fpadd_top_tb.sv
module fpadd_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_a, in_b;
  logic        in_op;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_overflow, out_underflow;

  fpadd_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op),
    .out_valid(out_valid), .out_result(out_result),
    .out_overflow(out_overflow), .out_underflow(out_underflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic        unf;
    int          due;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_bit(input logic act, input logic expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic op,
                      input logic [31:0] r, input logic ovf, input logic unf, input string tag);
    exp_item_t it;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    in_op = op;
    it.res = r; it.ovf = ovf; it.unf = unf; it.due = cyc + 3; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    in_a = 'x;
    in_b = 'x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops expected items as results emerge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_item_t it;
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12: unexpected result %h, expected none", out_result);
      end else begin
        it = sb_q.pop_front();
        if (out_result !== it.res || out_overflow !== it.ovf || out_underflow !== it.unf) begin
          n_bad++;
          $display("FAIL %s: actual %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
                   it.tag, out_result, out_overflow, out_underflow, it.res, it.ovf, it.unf);
        end
        if (cyc != it.due) begin
          n_bad++;
          $display("FAIL R12 (%s): result at cycle %0d expected cycle %0d", it.tag, cyc, it.due);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    in_valid = 1'b0;
    in_a = '0;
    in_b = '0;
    in_op = 1'b0;
    rst_n = 1'b0;
    idle(3);
    check_bit(in_ready, 1'b0, "R12 ready low in reset");
    check_bit(out_valid, 1'b0, "R12 valid low in reset");
    rst_n = 1'b1;
    idle(5);
    check_bit(in_ready, 1'b1, "R12 ready after reset");
    check_bit(out_valid, 1'b0, "R12 valid idle after reset");

    // R1 normal additions
    send(32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 1'b0, 1'b0, "R1 1+2");
    send(32'hC0A00000, 32'hBF400000, 1'b0, 32'hC0B80000, 1'b0, 1'b0, "R1 -5-0.75");
    // R2 subtraction
    send(32'h3F000000, 32'h3EE00000, 1'b1, 32'h3D800000, 1'b0, 1'b0, "R2 0.5-0.4375");
    // R3 zero operands
    send(32'h00000000, 32'h40490FDB, 1'b0, 32'h40490FDB, 1'b0, 1'b0, "R3 0+b");
    send(32'h12345678, 32'h80000000, 1'b0, 32'h12345678, 1'b0, 1'b0, "R3 a+(-0)");
    send(32'h00000000, 32'h40490FDB, 1'b1, 32'hC0490FDB, 1'b0, 1'b0, "R3 0-b");
    send(32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R3 denormal a");
    send(32'h80000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0, 1'b0, "R3 -0+0");
    idle(2);
    // R4 alignment beyond extension bits
    send(32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R4 1+2^-30");
    send(32'h3F800000, 32'h33400000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R4 1+1.5*2^-25");
    // R5 normalization
    send(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R5 1+1");
    send(32'h3F800000, 32'h33800000, 1'b1, 32'h3F7FFFFF, 1'b0, 1'b0, "R5 1-2^-24");
    send(32'h3F800000, 32'hC0000000, 1'b0, 32'hBF800000, 1'b0, 1'b0, "R5 1+(-2)");
    // R6 rounding
    send(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R6 tie even down");
    send(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, "R6 tie even up");
    send(32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 1'b0, "R6 above half");
    send(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R6 carry renorm");
    idle(1);
    // R7 cancellation
    send(32'h40490FDB, 32'h40490FDB, 1'b1, 32'h00000000, 1'b0, 1'b0, "R7 x-x");
    send(32'hC0490FDB, 32'h40490FDB, 1'b0, 32'h00000000, 1'b0, 1'b0, "R7 -x+x");
    // R8 overflow, incl. rounding carry into overflow
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R8 max+max");
    send(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0, "R8 -max-max");
    send(32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R8 round carry ovf");
    // R9 underflow
    send(32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1, "R9 pos underflow");
    send(32'h80C00000, 32'h80800000, 1'b1, 32'h80000000, 1'b0, 1'b1, "R9 neg underflow");
    idle(3);
    // R10 infinities
    send(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R10 inf+1");
    send(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0, "R10 1-inf");
    send(32'h7FC00001, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R10 nan as inf");
    send(32'hFF800000, 32'h40A00000, 1'b0, 32'hFF800000, 1'b0, 1'b0, "R10 -inf+5");
    // R11 opposite infinities
    send(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0, 1'b0, "R11 inf-inf");
    send(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, "R11 inf+-inf");

    idle(8);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R12: actual %0d results missing expected 0", sb_q.size());
    end
    done = 1;
    finish_run();
  end

endmodule